// File: doc/BRIEF.md
# Pointer Tag Arithmetic Unit

This execution unit works on 64-bit pointers that carry a 4-bit logical tag in bits [59:56] above a 56-bit address in bits [55:0]. Bits [63:60] are passed through untouched. The unit performs three tag-aware operations. The first places a pseudo-random tag into a pointer. The second offsets the address by a whole number of 16-byte granules and bumps the tag. The third compares the addresses of two pointers and reports the result as N, Z, C and V condition flags. The result value and the flags are combinational from the operands. The only state is a 16-bit pseudo-random generator and a 16-bit tag exclusion mask, and both change on the clock edge.

The exclusion mask names the tags that must never be produced. Bit k set means tag k is forbidden. Any tag the unit generates, whether random or computed, starts from a candidate value. It then steps upward modulo 16 until it reaches an allowed tag. If all 16 tags are forbidden, it yields tag 0. Operand fetch, instruction decode and register write-back belong to the surrounding pipeline.

Top module: `ptag_alu`

## Requirements
- R1: After reset the generator state is 16'h0001 and the exclusion mask is 16'h0000, so the first valid random-tag operation yields tag 1.
- R2: Random-tag operation (op_code 2'b00): result equals src_a with bits [59:56] replaced by the chosen tag. The candidate for that tag is the generator state bits [3:0] before the clock edge. flags is 4'b0000.
- R3: The generator advances on each clock edge that has a valid random-tag operation. The new state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. It holds on every other edge.
- R4: A pulse on seed_wr loads seed_data into the generator at the next edge, and this load wins over an advance in the same cycle.
- R5: A pulse on excl_wr loads excl_data into the exclusion mask at the next edge. A tag is chosen by stepping upward modulo 16 from the candidate past every tag whose mask bit is 1. If the mask is all ones, the tag is 0.
- R6: Add-with-tag operation (op_code 2'b01): result[55:0] = (src_a[55:0] + imm_off*16) mod 2^56. No carry reaches the tag. result[63:60] = src_a[63:60]. flags is 4'b0000.
- R7: Add-with-tag operation: the tag candidate is (src_a[59:56] + imm_tag) mod 16, and the exclusion rule of R5 then applies to it.
- R8: Compare operation (op_code 2'b10): both src_a[55:0] and src_b[55:0] are sign-extended from bit 55 to 64 bits, and the second is subtracted from the first. flags = {N,Z,C,V} as bits [3:0]. N is the difference's sign. Z is set when the difference is zero. C is set when there is no borrow, meaning the first value is unsigned greater than or equal to the second. V is signed overflow. result is 0. Bits [63:56] of both operands are ignored.
- R9: Op_code 2'b11 passes src_a to result unchanged with flags 4'b0000.
- R10: With op_valid low, result and flags are 0 and the generator does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 00 random tag, 01 add-with-tag, 10 compare, 11 pass |
| src_a | input | 64 | First pointer operand |
| src_b | input | 64 | Second pointer operand (compare only) |
| imm_off | input | 6 | Granule count added to the address |
| imm_tag | input | 4 | Value added to the tag |
| seed_wr | input | 1 | Load generator state |
| seed_data | input | 16 | New generator state |
| excl_wr | input | 1 | Load exclusion mask |
| excl_data | input | 16 | New exclusion mask, bit k forbids tag k |
| result | output | 64 | Result pointer |
| flags | output | 4 | {N,Z,C,V} |

## Verification
The generator and the mask are hidden state, and they can only be seen through random-tag results. A generator that skips an advance, advances twice, or ignores seed priority gives a wrong tag on the next valid random-tag operation. It is never more than one operation late. A corrupted mask bit can only be seen when an operation's candidate lands on or steps through that tag. For this reason the stimulus aims candidates directly at excluded tags, at runs of excluded tags that wrap past 15, and at a fully excluded mask. Address and flag errors show up in the same cycle as the operands.

// File: rtl/ptag_pkg.sv
package ptag_pkg;

  typedef enum logic [1:0] {
    OP_RAND = 2'b00,
    OP_ADDG = 2'b01,
    OP_CMP  = 2'b10,
    OP_PASS = 2'b11
  } ptag_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int unsigned GEN_W = 16;

  // Fibonacci shift with taps at 16, 14, 13, 11
  function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
    return {s[GEN_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/ptag_state.sv
module ptag_state
  import ptag_pkg::*;
#(
  parameter int unsigned TAG_W   = 4,
  parameter logic [GEN_W-1:0] GEN_RST = 16'h0001,
  localparam int unsigned NTAG   = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_wr,
  input  logic [GEN_W-1:0]  seed_data,
  input  logic              excl_wr,
  input  logic [NTAG-1:0]   excl_data,
  input  logic              gen_adv,
  output logic [TAG_W-1:0]  gen_cand,
  output logic [NTAG-1:0]   excl_mask
);

  logic [GEN_W-1:0] gen_q;
  logic [GEN_W-1:0] gen_nxt;

  always_comb begin
    gen_nxt = gen_q;
    if (seed_wr)      gen_nxt = seed_data;
    else if (gen_adv) gen_nxt = gen_step(gen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q     <= GEN_RST;
      excl_mask <= '0;
    end else begin
      gen_q <= gen_nxt;
      if (excl_wr) excl_mask <= excl_data;
    end
  end

  assign gen_cand = gen_q[TAG_W-1:0];

  // R4
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_wr |=> gen_q == $past(seed_data));

  // R3
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_wr && !gen_adv) |=> $stable(gen_q));

  // R3
  gen_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_wr && gen_adv && gen_q != '0) |=> gen_q != $past(gen_q));

  // R5
  excl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excl_wr |=> excl_mask == $past(excl_data));

endmodule

// File: rtl/ptag_tag_pick.sv
module ptag_tag_pick #(
  parameter int unsigned TAG_W = 4,
  localparam int unsigned NTAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] start,
  input  logic [NTAG-1:0]  mask,
  output logic [TAG_W-1:0] tag,
  output logic             all_excl
);

  logic [TAG_W-1:0] cand [NTAG];
  logic [NTAG-1:0]  ok;

  for (genvar i = 0; i < NTAG; i++) begin : g_cand
    assign cand[i] = start + TAG_W'(i);
    assign ok[i]   = !mask[cand[i]];
  end

  assign all_excl = (ok == '0);

  always_comb begin
    tag = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (ok[i]) tag = cand[i];
    end
  end

  // R5
  pick_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_excl |-> !mask[tag]);

  // R5
  pick_all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> tag == '0);

  // R5
  pick_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[start] |-> tag == start);

endmodule

// File: rtl/ptag_addr_unit.sv
module ptag_addr_unit
  import ptag_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned ADDR_W     = 56,
  parameter int unsigned OFF_W      = 6,
  parameter int unsigned GRAN_SHIFT = 4,
  localparam int unsigned EXT_W     = DATA_W - ADDR_W,
  localparam int unsigned PAD_W     = ADDR_W - OFF_W - GRAN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [OFF_W-1:0]  imm_off,
  output logic [ADDR_W-1:0] sum_addr,
  output nzcv_t             cmp_flags
);

  function automatic logic [ADDR_W-1:0] granule_add(input logic [ADDR_W-1:0] base,
                                                    input logic [OFF_W-1:0]  cnt);
    return base + {{PAD_W{1'b0}}, cnt, {GRAN_SHIFT{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] sext(input logic [ADDR_W-1:0] x);
    return {{EXT_W{x[ADDR_W-1]}}, x};
  endfunction

  function automatic nzcv_t sub_flags(input logic [DATA_W-1:0] x,
                                      input logic [DATA_W-1:0] y);
    logic [DATA_W:0] d;
    nzcv_t f;
    d   = {1'b0, x} + {1'b0, ~y} + {{DATA_W{1'b0}}, 1'b1};
    f.n = d[DATA_W-1];
    f.z = (d[DATA_W-1:0] == '0);
    f.c = d[DATA_W];
    f.v = (x[DATA_W-1] != y[DATA_W-1]) && (d[DATA_W-1] != x[DATA_W-1]);
    return f;
  endfunction

  assign sum_addr  = granule_add(a_addr, imm_off);
  assign cmp_flags = sub_flags(sext(a_addr), sext(b_addr));

  // R8
  cmp_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr == b_addr) |-> (cmp_flags.z && cmp_flags.c && !cmp_flags.n));

  // R6
  addr_gran_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_addr[GRAN_SHIFT-1:0] == a_addr[GRAN_SHIFT-1:0]);

endmodule

// File: rtl/ptag_alu.sv
module ptag_alu
  import ptag_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned ADDR_W     = 56,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned OFF_W      = 6,
  parameter int unsigned GRAN_SHIFT = 4,
  parameter logic [15:0] GEN_RST    = 16'h0001,
  localparam int unsigned NTAG      = 1 << TAG_W,
  localparam int unsigned TAG_LSB   = ADDR_W,
  localparam int unsigned TAG_MSB   = ADDR_W + TAG_W - 1,
  localparam int unsigned TOP_LSB   = ADDR_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [OFF_W-1:0]  imm_off,
  input  logic [TAG_W-1:0]  imm_tag,
  input  logic              seed_wr,
  input  logic [15:0]       seed_data,
  input  logic              excl_wr,
  input  logic [NTAG-1:0]   excl_data,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags
);

  ptag_op_e op;
  assign op = ptag_op_e'(op_code);

  // named events for assertions
  logic is_rand, is_addg, is_cmp;
  assign is_rand = op_valid && (op == OP_RAND);
  assign is_addg = op_valid && (op == OP_ADDG);
  assign is_cmp  = op_valid && (op == OP_CMP);

  logic [TAG_W-1:0]  gen_cand;
  logic [NTAG-1:0]   excl_mask;
  logic [TAG_W-1:0]  pick_start;
  logic [TAG_W-1:0]  pick_tag;
  logic              pick_all;
  logic [ADDR_W-1:0] sum_addr;
  nzcv_t             cmp_flags;
  logic              unused_b_hi;

  assign unused_b_hi = ^src_b[DATA_W-1:ADDR_W];

  ptag_state #(.TAG_W(TAG_W), .GEN_RST(GEN_RST)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_wr   (seed_wr),
    .seed_data (seed_data),
    .excl_wr   (excl_wr),
    .excl_data (excl_data),
    .gen_adv   (is_rand),
    .gen_cand  (gen_cand),
    .excl_mask (excl_mask)
  );

  assign pick_start = is_rand ? gen_cand : (src_a[TAG_MSB:TAG_LSB] + imm_tag);

  ptag_tag_pick #(.TAG_W(TAG_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (pick_start),
    .mask     (excl_mask),
    .tag      (pick_tag),
    .all_excl (pick_all)
  );

  ptag_addr_unit #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .GRAN_SHIFT (GRAN_SHIFT)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_addr    (src_a[ADDR_W-1:0]),
    .b_addr    (src_b[ADDR_W-1:0]),
    .imm_off   (imm_off),
    .sum_addr  (sum_addr),
    .cmp_flags (cmp_flags)
  );

  always_comb begin
    result = '0;
    flags  = '0;
    if (op_valid) begin
      unique case (op)
        OP_RAND: result = {src_a[DATA_W-1:TOP_LSB], pick_tag, src_a[ADDR_W-1:0]};
        OP_ADDG: result = {src_a[DATA_W-1:TOP_LSB], pick_tag, sum_addr};
        OP_CMP:  flags  = cmp_flags;
        OP_PASS: result = src_a;
        default: result = '0;
      endcase
    end
  end

  // R2
  rand_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rand |-> (result[ADDR_W-1:0] == src_a[ADDR_W-1:0] &&
                 result[DATA_W-1:TOP_LSB] == src_a[DATA_W-1:TOP_LSB]));

  // R5
  tag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_rand || is_addg) && !pick_all) |-> !excl_mask[result[TAG_MSB:TAG_LSB]]);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (result == '0 && flags == '0));

  // R9
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cmp |-> flags == '0);

  // R8
  cmp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |-> result == '0);

endmodule

// File: tb/tb_ptag_alu.sv
module tb_ptag_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [5:0]  imm_off = '0;
  logic [3:0]  imm_tag = '0;
  logic        seed_wr = 1'b0;
  logic [15:0] seed_data = '0;
  logic        excl_wr = 1'b0;
  logic [15:0] excl_data = '0;
  logic [63:0] result;
  logic [3:0]  flags;

  int total = 0;
  int bad = 0;
  logic [15:0] gen_model;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptag_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .imm_off(imm_off), .imm_tag(imm_tag),
    .seed_wr(seed_wr), .seed_data(seed_data), .excl_wr(excl_wr),
    .excl_data(excl_data), .result(result), .flags(flags)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [5:0]  off;
    logic [3:0]  tg;
    logic [15:0] mask;
    logic [63:0] exp_res;
    logic [3:0]  exp_flg;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R6 R7 plain add
    '{2'b01, 64'h0300_0000_0000_1000, 64'h0, 6'd1,  4'd1, 16'h0000, 64'h0400_0000_0000_1010, 4'b0000},
    // R6 address wraps inside 56 bits
    '{2'b01, 64'hF2FF_FFFF_FFFF_FFF0, 64'h0, 6'd1,  4'd0, 16'h0000, 64'hF200_0000_0000_0000, 4'b0000},
    // R7 tag wraps mod 16, max offset
    '{2'b01, 64'h0F00_0000_0000_0000, 64'h0, 6'd63, 4'd3, 16'h0000, 64'h0200_0000_0000_03F0, 4'b0000},
    // R5 R7 skip two excluded tags
    '{2'b01, 64'h0500_0000_0000_0020, 64'h0, 6'd0,  4'd1, 16'h00C0, 64'h0800_0000_0000_0020, 4'b0000},
    // R5 all excluded
    '{2'b01, 64'h0700_0000_0000_0040, 64'h0, 6'd2,  4'd5, 16'hFFFF, 64'h0000_0000_0000_0060, 4'b0000},
    // R5 skip wraps past 15
    '{2'b01, 64'h0E00_0000_0000_0000, 64'h0, 6'd0,  4'd1, 16'h8001, 64'h0100_0000_0000_0000, 4'b0000},
    // R8 equal addresses, tags differ
    '{2'b10, 64'h0500_0000_0000_0010, 64'h0A00_0000_0000_0010, 6'd0, 4'd0, 16'h0, 64'h0, 4'b0110},
    // R8 borrow, negative
    '{2'b10, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007, 6'd0, 4'd0, 16'h0, 64'h0, 4'b1000},
    // R8 sign extension of bit 55
    '{2'b10, 64'h0080_0000_0000_0000, 64'h0000_0000_0000_0001, 6'd0, 4'd0, 16'h0, 64'h0, 4'b1010},
    // R8 positive minus sign-extended negative
    '{2'b10, 64'h007F_FFFF_FFFF_FFFF, 64'h0080_0000_0000_0000, 6'd0, 4'd0, 16'h0, 64'h0, 4'b0000},
    // R8 upper byte ignored
    '{2'b10, 64'hFF00_0000_0000_0009, 64'h1200_0000_0000_0003, 6'd0, 4'd0, 16'h0, 64'h0, 4'b0010},
    // R9 pass
    '{2'b11, 64'h1234_5678_9ABC_DEF0, 64'h0, 6'd0, 4'd0, 16'h0, 64'h1234_5678_9ABC_DEF0, 4'b0000}
  };

  function automatic logic [15:0] model_step(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return (s << 1) | {15'd0, fb};
  endfunction

  function automatic logic [3:0] model_pick(input logic [3:0] st, input logic [15:0] m);
    logic [3:0] t;
    t = st;
    for (int k = 0; k < 16; k++) begin
      if (!m[t]) return t;
      t = t + 4'd1;
    end
    return 4'd0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_mask(input logic [15:0] m);
    @(negedge clk);
    op_valid = 1'b0;
    excl_wr = 1'b1;
    excl_data = m;
    @(negedge clk);
    excl_wr = 1'b0;
  endtask

  task automatic rand_op(input logic [63:0] a, input logic [15:0] m, input string req);
    logic [63:0] exp;
    op_valid = 1'b1;
    op_code = 2'b00;
    src_a = a;
    #(CLK_PERIOD/4);
    exp = a;
    exp[59:56] = model_pick(gen_model[3:0], m);
    check(req, result, exp);
    check(req, {60'd0, flags}, 64'd0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    gen_model = 16'h0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 first random tag after reset
    @(negedge clk);
    rand_op(64'hCA00_0000_0000_1234, 16'h0, "R1");
    check("R1", {60'd0, result[59:56]}, 64'd1);
    @(posedge clk); gen_model = model_step(gen_model);

    // R10 idle: outputs zero, no advance
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'b00; src_a = 64'hFFFF_FFFF_FFFF_FFFF;
    #(CLK_PERIOD/4);
    check("R10", result, 64'd0);
    check("R10", {60'd0, flags}, 64'd0);
    @(negedge clk);
    rand_op(64'h0000_0000_0000_0ABC, 16'h0, "R10");
    @(posedge clk); gen_model = model_step(gen_model);

    // R3 non-random ops do not advance
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'b01; src_a = 64'h0; imm_off = 6'd3; imm_tag = 4'd2;
    @(negedge clk);
    op_code = 2'b10;
    @(negedge clk);
    rand_op(64'h3300_0000_0000_0001, 16'h0, "R3");
    @(posedge clk); gen_model = model_step(gen_model);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rand_op(64'h0000_1111_2222_3333, 16'h0, "R3");
      @(posedge clk); gen_model = model_step(gen_model);
    end

    // table
    for (int i = 0; i < NV; i++) begin
      load_mask(VECS[i].mask);
      op_valid = 1'b1; op_code = VECS[i].op; src_a = VECS[i].a; src_b = VECS[i].b;
      imm_off = VECS[i].off; imm_tag = VECS[i].tg;
      #(CLK_PERIOD/4);
      check($sformatf("R6/R7/R8/R9 vec%0d result", i), result, VECS[i].exp_res);
      check($sformatf("R8 vec%0d flags", i), {60'd0, flags}, {60'd0, VECS[i].exp_flg});
    end

    // R4 seed load wins over advance
    load_mask(16'h0000);
    seed_wr = 1'b1; seed_data = 16'hBEEF;
    rand_op(64'h0000_0000_0000_0040, 16'h0, "R4");
    @(posedge clk); gen_model = 16'hBEEF;
    @(negedge clk);
    seed_wr = 1'b0;
    rand_op(64'h0000_0000_0000_0050, 16'h0, "R4");
    check("R4", {60'd0, result[59:56]}, 64'hF);
    @(posedge clk); gen_model = model_step(gen_model);

    // R5 random tag steps past excluded tag 15
    @(negedge clk);
    op_valid = 1'b0;
    seed_wr = 1'b1; seed_data = 16'h123F;
    excl_wr = 1'b1; excl_data = 16'h8000;
    @(posedge clk); gen_model = 16'h123F;
    @(negedge clk);
    seed_wr = 1'b0; excl_wr = 1'b0;
    rand_op(64'h5500_0000_0000_0777, 16'h8000, "R5");
    check("R5", {60'd0, result[59:56]}, 64'd0);
    @(posedge clk); gen_model = model_step(gen_model);

    // R5 all excluded random tag
    load_mask(16'hFFFF);
    rand_op(64'h0F00_0000_0000_0888, 16'hFFFF, "R5");
    check("R5", {60'd0, result[59:56]}, 64'd0);
    @(posedge clk); gen_model = model_step(gen_model);

    @(negedge clk);
    op_valid = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule